// File: doc/BRIEF.md
# Four-Mode Barrel Shifter

This block is the combinational shift unit of a 32-bit RISC core. It takes an operand and produces, within the same cycle, the operand shifted by a count of 0 to 31 in one of four ways: logical right, arithmetic right, logical left, or circular left (rotate). The unit has no clock and no storage. Its result is ready as soon as its inputs settle.

The count comes from one of two places. The instruction carries a 5-bit constant count. When that constant is nonzero, it is the count. A constant of zero is an escape: the count is then the low five bits of a register operand, which the caller supplies on a separate input. The 2-bit mode is the low two bits of the shift opcode, so the instruction decoder can pass those bits straight through.

Internally the shift is a chain of five mux stages. Each stage moves the data by a power of two, 1, 2, 4, 8 or 16 bit positions, when the matching bit of the count is set.

Top module: `bshift_unit`

## Requirements
- R1: When `cnt_const_i` is nonzero, the shift count equals `cnt_const_i`, and `cnt_reg_i` has no effect on `result_o`.
- R2: When `cnt_const_i` is zero, the shift count equals `cnt_reg_i`.
- R3: Mode 2'b10 is a logical right shift by n. The top n bits of `result_o` are zero and `result_o[31-n:0]` equals `opnd_i[31:n]`.
- R4: Mode 2'b11 is an arithmetic right shift by n. The top n bits of `result_o` are copies of `opnd_i[31]`, and the remaining bits equal `opnd_i[31:n]`.
- R5: Mode 2'b00 is a logical left shift by n. The bottom n bits of `result_o` are zero and `result_o[31:n]` equals `opnd_i[31-n:0]`.
- R6: Mode 2'b01 is a rotate left by n. Bit i of `result_o` equals bit (i-n) mod 32 of `opnd_i`.
- R7: A count of zero returns `opnd_i` unchanged in every mode.
- R8: Every count from 1 to 31, including the maximum of 31, gives the result defined for its mode.
- R9: `result_o` is a purely combinational function of the inputs: it reflects new inputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand to shift |
| cnt_const_i | input | 5 | Constant count from the instruction; zero selects the register count |
| cnt_reg_i | input | 5 | Low five bits of the count register |
| mode_i | input | 2 | Shift mode: 00 left, 01 rotate left, 10 logical right, 11 arithmetic right |
| result_o | output | 32 | Shifted operand |

## Verification
Count selection and mode behaviour act in the same cycle. The clearest cases are the zero-constant escape feeding a register count into a rotate or an arithmetic shift, and a zero count on both sources meeting each mode. The bench provokes these by changing the constant field, the register count and the mode together in one step. In other steps it holds the constant nonzero while it varies the register count. Each result is judged against a bit-by-bit model in the bench, which is sampled one nanosecond after the inputs change and with no clock edge in between.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    parameter int unsigned DATA_W = 32;
    localparam int unsigned CNT_W = $clog2(DATA_W);

    // Mode values are the low two bits of the shift opcodes.
    typedef enum logic [1:0] {
        MODE_SHL = 2'b00,
        MODE_ROL = 2'b01,
        MODE_SHR = 2'b10,
        MODE_SRA = 2'b11
    } shift_mode_e;

    // Distance moved by stage k of the log network.
    function automatic int unsigned stage_dist(input int unsigned k);
        return 32'd1 << k;
    endfunction

endpackage

// File: rtl/bshift_count.sv
module bshift_count
    import bshift_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic [CW-1:0] const_i,
    input  logic [CW-1:0] reg_i,
    output logic [CW-1:0] amt_o
);

    logic use_reg;

    always_comb begin
        use_reg = (const_i == '0);
        amt_o   = use_reg ? reg_i : const_i;
    end

endmodule

// File: rtl/bshift_stage.sv
module bshift_stage
    import bshift_pkg::*;
#(
    parameter int unsigned DW   = DATA_W,
    parameter int unsigned DIST = 1
) (
    input  logic [DW-1:0] d_i,
    input  logic          en_i,
    input  shift_mode_e   mode_i,
    output logic [DW-1:0] q_o
);

    always_comb begin
        q_o = d_i;
        if (en_i) begin
            case (mode_i)
                MODE_SHL: q_o = {d_i[DW-1-DIST:0], {DIST{1'b0}}};
                MODE_ROL: q_o = {d_i[DW-1-DIST:0], d_i[DW-1 -: DIST]};
                MODE_SHR: q_o = {{DIST{1'b0}}, d_i[DW-1:DIST]};
                MODE_SRA: q_o = {{DIST{d_i[DW-1]}}, d_i[DW-1:DIST]};
                default:  q_o = d_i;
            endcase
        end
    end

endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
    import bshift_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    localparam int unsigned CW = $clog2(DW)
) (
    input  logic [DW-1:0] opnd_i,
    input  logic [CW-1:0] cnt_const_i,
    input  logic [CW-1:0] cnt_reg_i,
    input  logic [1:0]    mode_i,
    output logic [DW-1:0] result_o
);

    shift_mode_e   mode;
    logic [CW-1:0] amt;
    logic [DW-1:0] lvl [CW+1];

    assign mode   = shift_mode_e'(mode_i);
    assign lvl[0] = opnd_i;

    bshift_count #(.CW(CW)) u_count (
        .const_i (cnt_const_i),
        .reg_i   (cnt_reg_i),
        .amt_o   (amt)
    );

    for (genvar k = 0; k < CW; k++) begin : g_stage
        bshift_stage #(.DW(DW), .DIST(stage_dist(k))) u_stage (
            .d_i    (lvl[k]),
            .en_i   (amt[k]),
            .mode_i (mode),
            .q_o    (lvl[k+1])
        );
    end

    assign result_o = lvl[CW];

    always_comb begin
        if (amt == '0) begin
            // R7
            zero_count_pass_chk: assert (result_o == opnd_i);
        end
        if (mode == MODE_SHR && amt != '0) begin
            // R3
            shr_top_zero_chk: assert (result_o[DW-1] == 1'b0);
        end
        if (mode == MODE_SRA) begin
            // R4
            sra_sign_keep_chk: assert (result_o[DW-1] == opnd_i[DW-1]);
        end
        if (mode == MODE_SHL && amt != '0) begin
            // R5
            shl_low_zero_chk: assert (result_o[0] == 1'b0);
        end
        if (mode == MODE_ROL) begin
            // R6
            rol_ones_keep_chk: assert ($countones(result_o) == $countones(opnd_i));
        end
    end

endmodule

// File: tb/bshift_unit_test.sv
`timescale 1ns/1ps
module bshift_unit_test;

    logic        clk = 1'b0;
    logic [31:0] opnd;
    logic [4:0]  cconst;
    logic [4:0]  creg;
    logic [1:0]  mode;
    logic [31:0] result;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bshift_unit uut (
        .opnd_i      (opnd),
        .cnt_const_i (cconst),
        .cnt_reg_i   (creg),
        .mode_i      (mode),
        .result_o    (result)
    );

    function automatic logic [31:0] model(input logic [31:0] x, input logic [4:0] c,
                                         input logic [4:0] r, input logic [1:0] m);
        int n;
        logic [31:0] y;
        n = (c != 5'd0) ? int'(c) : int'(r);
        for (int i = 0; i < 32; i++) begin
            case (m)
                2'b00: y[i] = (i >= n) ? x[i-n] : 1'b0;
                2'b01: y[i] = x[(i - n + 32) % 32];
                2'b10: y[i] = (i + n < 32) ? x[i+n] : 1'b0;
                default: y[i] = (i + n < 32) ? x[i+n] : x[31];
            endcase
        end
        return y;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [31:0] x, input logic [4:0] c,
                         input logic [4:0] r, input logic [1:0] m);
        @(negedge clk);
        opnd = x; cconst = c; creg = r; mode = m;
        #1;
        check(tag, result, model(x, c, r, m));
    endtask

    task automatic t_idle();
        apply("idle", 32'h0, 5'd0, 5'd0, 2'b00);
        check("idle zero", result, 32'h0);
    endtask

    task automatic t_const_count();
        // R1: register count must have no effect while the constant is nonzero
        apply("R1 c=4 r=0", 32'h1234_5678, 5'd4, 5'd0, 2'b00);
        check("R1 const", result, 32'h2345_6780);
        apply("R1 c=4 r=13", 32'h1234_5678, 5'd4, 5'd13, 2'b00);
        check("R1 reg ignored", result, 32'h2345_6780);
    endtask

    task automatic t_reg_count();
        // R2: zero constant selects the register count
        apply("R2 r=8 shr", 32'hA5C3_0F96, 5'd0, 5'd8, 2'b10);
        check("R2 value", result, 32'h00A5_C30F);
        apply("R2 r=3 rol", 32'h8000_0001, 5'd0, 5'd3, 2'b01);
    endtask

    task automatic t_right();
        // R3 logical right
        apply("R3 shr 1", 32'h8000_0000, 5'd1, 5'd0, 2'b10);
        check("R3 val", result, 32'h4000_0000);
        apply("R3 shr 16", 32'hFFFF_0000, 5'd16, 5'd0, 2'b10);
        // R4 arithmetic right, negative and positive operand
        apply("R4 sra neg", 32'h8000_0000, 5'd4, 5'd0, 2'b11);
        check("R4 val", result, 32'hF800_0000);
        apply("R4 sra pos", 32'h7000_0000, 5'd0, 5'd5, 2'b11);
        check("R4 pos", result, 32'h0380_0000);
    endtask

    task automatic t_left();
        // R5 logical left
        apply("R5 shl 31", 32'hFFFF_FFFF, 5'd31, 5'd0, 2'b00);
        check("R5 val", result, 32'h8000_0000);
        // R6 rotate left, wrap of high bits into low bits
        apply("R6 rol 4", 32'hF000_000A, 5'd4, 5'd0, 2'b01);
        check("R6 val", result, 32'h0000_00AF);
        apply("R6 rol 31", 32'h0000_0001, 5'd31, 5'd0, 2'b01);
        check("R6 wrap", result, 32'h8000_0000);
    endtask

    task automatic t_zero_count();
        // R7: zero count in every mode returns the operand
        for (int m = 0; m < 4; m++) begin
            apply("R7 zero", 32'hDEAD_BEEF, 5'd0, 5'd0, 2'(m));
            check("R7 pass", result, 32'hDEAD_BEEF);
        end
    endtask

    task automatic t_sweep();
        // R8: every count in every mode, from each count source
        for (int m = 0; m < 4; m++) begin
            for (int n = 1; n < 32; n++) begin
                apply("R8 const", 32'h9E37_79B9, 5'(n), 5'(31 - n), 2'(m));
                apply("R8 reg",   32'h6C07_8B15, 5'd0, 5'(n), 2'(m));
            end
        end
    endtask

    task automatic t_comb();
        // R9: output follows inputs with no clock edge in between
        @(posedge clk);
        #0.5;
        opnd = 32'h0000_00FF; cconst = 5'd8; creg = 5'd0; mode = 2'b00;
        #1;
        check("R9 no edge", result, 32'h0000_FF00);
        mode = 2'b10;
        #0.5;
        check("R9 mode change", result, 32'h0000_0000);
    endtask

    initial begin
        opnd = '0; cconst = '0; creg = '0; mode = '0;
        t_idle();
        t_const_count();
        t_reg_count();
        t_right();
        t_left();
        t_zero_count();
        t_sweep();
        t_comb();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule